// File: doc/BRIEF.md
# Clock Output-Enable Configuration Slave (Two-Wire Serial)

This block sits beside a multi-output clock distribution buffer and keeps one enable bit per clock output. A host reaches it over a two-wire serial bus (I2C signalling, open-drain data line). It answers a fixed seven-bit slave address, which is a parameter. On a write, the master first sends two header bytes, a command code and a byte count. The block acknowledges both and throws their values away. Every later data byte loads the next enable register, always starting from register 0 and moving upward, until a STOP or a repeated START ends the transfer.

A read transfer returns the registers from register 0 upward so the host can confirm them. Registers that a write did not reach keep their values. An active-low power-down input takes the block off the bus and freezes the enable bits. The bus lines are brought into the system clock domain through a two-flop synchroniser before any START, STOP or edge is decoded.

Top module: `oecfg_i2c_slave`

## Requirements
- R1: After a matching write address, the first two bytes (command, count) are acknowledged and change no enable bit.
- R2: From the third byte after the address on, data bytes load register 0, then 1, then 2, and so on. Bytes beyond the last register are acknowledged and dropped. At most one register changes per system clock cycle.
- R3: A STOP after any complete byte ends the write. Registers written keep their new value and registers not reached keep their old value.
- R4: The block acknowledges a matching address byte and every byte written after it by pulling SDA low (sda_oe = 1) for the ninth SCL clock. sda_oe only changes while SCL is low.
- R5: An address byte with the R/W bit (bit 0) set to 1 makes the block return register 0, 1, 2, ... MSB first, and 0xFF for any index past the last register. A master NACK ends the read and releases SDA.
- R6: Reset sets every enable bit to 1.
- R7: oe_bits[8*b+i] is bit i of register b. A value of 1 enables that clock output and 0 holds it low.
- R8: While pwr_dn_n is low, sda_oe stays 0 from the next cycle on, nothing is acknowledged, and oe_bits does not change.
- R9: An address byte whose upper seven bits differ from SLAVE_ADDR (default 0x69) is not acknowledged. The block then ignores the bus until the next START.
- R10: A repeated START restarts address decoding and resets the register index to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn_n | input | 1 | Active-low power-down, quasi-static level |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| oe_bits | output | NUM_BYTES*8 | Per-output clock enable bits |

## Verification
The assertions assume a well-behaved master. It changes SDA only while SCL is low, except to form START and STOP. It never issues START or STOP while the block holds SDA low. It changes pwr_dn_n only while the bus is idle. The bench master keeps every SCL phase twenty system clocks long, far longer than the synchroniser delay, so each edge decodes cleanly. It releases SDA before every ninth clock and every read bit, and it asserts power-down only between transfers.

// File: rtl/oecfg_pkg.sv
package oecfg_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_RX_ACK,
        PH_TX,
        PH_TX_ACK
    } phase_e;

endpackage

// File: rtl/oecfg_sync.sv
module oecfg_sync #(
    parameter int              WIDTH   = 2,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q[s] <= RST_VAL;
            end else if (s == 0) begin
                chain_q[s] <= din;
            end else begin
                chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/oecfg_bus_events.sv
module oecfg_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    // data edge while the clock stays high marks a bus condition
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/oecfg_i2c_slave.sv
module oecfg_i2c_slave
    import oecfg_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = 7'h69,
    parameter int         NUM_BYTES   = 3,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pwr_dn_n,
    input  logic                        scl_i,
    input  logic                        sda_i,
    output logic                        sda_oe,
    output logic [NUM_BYTES*BYTE_W-1:0] oe_bits
);

    localparam int IDX_W = $clog2(NUM_BYTES + 1);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(NUM_BYTES);
    localparam logic [1:0] HDR_ADDR = 2'd0;
    localparam logic [1:0] HDR_DATA = 2'd3;

    typedef struct packed {
        phase_e                               phase;
        logic [3:0]                           bit_cnt;
        logic [BYTE_W-1:0]                    shreg;
        logic [1:0]                           hdr;
        logic                                 rd;
        logic                                 ack_seen;
        logic [IDX_W-1:0]                     idx;
        logic                                 drv;
        logic [NUM_BYTES-1:0][BYTE_W-1:0]     regs;
    } state_t;

    state_t st_d, st_q;

    logic [1:0] line_s;
    logic       scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] rd_byte;

    oecfg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_i, sda_i}),
        .dout  (line_s)
    );

    oecfg_bus_events events_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (line_s[1]),
        .sda_s     (line_s[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    // read-back byte selected by the current index, all ones past the end
    always_comb begin
        rd_byte = '1;
        for (int b = 0; b < NUM_BYTES; b++) begin
            if (st_q.idx == IDX_W'(b)) rd_byte = st_q.regs[b];
        end
    end

    always_comb begin
        st_d = st_q;
        if (!pwr_dn_n) begin
            st_d.phase = PH_IDLE;
            st_d.drv   = 1'b0;
        end else if (start_det) begin
            st_d.phase   = PH_RX;
            st_d.bit_cnt = '0;
            st_d.hdr     = HDR_ADDR;
            st_d.idx     = '0;
            st_d.rd      = 1'b0;
            st_d.drv     = 1'b0;
        end else if (stop_det) begin
            st_d.phase = PH_IDLE;
            st_d.drv   = 1'b0;
        end else begin
            unique case (st_q.phase)
                PH_RX: begin
                    if (scl_rise) begin
                        st_d.shreg   = {st_q.shreg[BYTE_W-2:0], line_s[0]};
                        st_d.bit_cnt = st_q.bit_cnt + 4'd1;
                    end else if (scl_fall && st_q.bit_cnt == 4'd8) begin
                        if (st_q.hdr == HDR_ADDR) begin
                            if (st_q.shreg[7:1] == SLAVE_ADDR) begin
                                st_d.rd    = st_q.shreg[0];
                                st_d.hdr   = 2'd1;
                                st_d.drv   = 1'b1;
                                st_d.phase = PH_RX_ACK;
                            end else begin
                                st_d.phase = PH_IDLE;
                            end
                        end else begin
                            if (st_q.hdr == HDR_DATA) begin
                                for (int b = 0; b < NUM_BYTES; b++) begin
                                    if (st_q.idx == IDX_W'(b)) st_d.regs[b] = st_q.shreg;
                                end
                                if (st_q.idx < IDX_END) st_d.idx = st_q.idx + 1'b1;
                            end else begin
                                st_d.hdr = st_q.hdr + 2'd1;
                            end
                            st_d.drv   = 1'b1;
                            st_d.phase = PH_RX_ACK;
                        end
                    end
                end
                PH_RX_ACK: begin
                    if (scl_fall) begin
                        st_d.bit_cnt = '0;
                        if (st_q.rd) begin
                            st_d.shreg = rd_byte;
                            st_d.drv   = ~rd_byte[7];
                            if (st_q.idx < IDX_END) st_d.idx = st_q.idx + 1'b1;
                            st_d.phase = PH_TX;
                        end else begin
                            st_d.drv   = 1'b0;
                            st_d.phase = PH_RX;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_fall) begin
                        st_d.bit_cnt = st_q.bit_cnt + 4'd1;
                        if (st_q.bit_cnt == 4'd7) begin
                            st_d.drv   = 1'b0;
                            st_d.phase = PH_TX_ACK;
                        end else begin
                            st_d.shreg = {st_q.shreg[BYTE_W-2:0], 1'b1};
                            st_d.drv   = ~st_q.shreg[6];
                        end
                    end
                end
                PH_TX_ACK: begin
                    if (scl_rise) begin
                        st_d.ack_seen = ~line_s[0];
                    end else if (scl_fall) begin
                        if (st_q.ack_seen) begin
                            st_d.bit_cnt = '0;
                            st_d.shreg   = rd_byte;
                            st_d.drv     = ~rd_byte[7];
                            if (st_q.idx < IDX_END) st_d.idx = st_q.idx + 1'b1;
                            st_d.phase   = PH_TX;
                        end else begin
                            st_d.phase = PH_IDLE;
                        end
                    end
                end
                default: begin
                    st_d.drv = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase    <= PH_IDLE;
            st_q.bit_cnt  <= '0;
            st_q.shreg    <= '0;
            st_q.hdr      <= HDR_ADDR;
            st_q.rd       <= 1'b0;
            st_q.ack_seen <= 1'b0;
            st_q.idx      <= '0;
            st_q.drv      <= 1'b0;
            st_q.regs     <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_oe  = st_q.drv;
    assign oe_bits = st_q.regs;

endmodule

// File: rtl/oecfg_i2c_slave_chk.sv
module oecfg_i2c_slave_chk #(
    parameter int NUM_BYTES = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   pwr_dn_n,
    input logic                   scl_i,
    input logic                   sda_oe,
    input logic [NUM_BYTES*8-1:0] oe_bits
);

    logic [NUM_BYTES*8-1:0] oe_prev;
    logic [NUM_BYTES-1:0]   byte_chg;

    always_ff @(posedge clk) begin
        oe_prev <= oe_bits;
    end

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_chg
        assign byte_chg[b] = (oe_bits[b*8 +: 8] != oe_prev[b*8 +: 8]);
    end

    // R6: held reset leaves every enable bit set
    always @(posedge clk) begin
        if (!rst_n && $past(!rst_n)) begin
            assert_reset_all_on_R6: assert (oe_bits == '1);
        end
    end

    assert_one_byte_per_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(byte_chg));

    assert_sda_moves_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_dn_n && $past(pwr_dn_n) && !$stable(sda_oe)) |-> !scl_i);

    assert_pd_releases_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_dn_n |=> !sda_oe);

    assert_pd_freezes_regs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_dn_n |=> $stable(oe_bits));

endmodule

bind oecfg_i2c_slave oecfg_i2c_slave_chk #(.NUM_BYTES(NUM_BYTES)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_dn_n (pwr_dn_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .oe_bits  (oe_bits)
);

// File: tb/oecfg_i2c_slave_tb_top.sv
module oecfg_i2c_slave_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int         NB   = 3;
    localparam logic [6:0] ADDR = 7'h69;
    localparam int         Q    = 20;

    // vector: {count[3:0], data d3..d0 [31:0], expected oe [23:0]}
    localparam int NVEC = 5;
    localparam logic [59:0] VEC [NVEC] = '{
        {4'd3, 32'h000F3CA5, 24'h0F3CA5},
        {4'd1, 32'h00000000, 24'h0F3C00},
        {4'd2, 32'h000081FF, 24'h0F81FF},
        {4'd0, 32'h00000000, 24'h0F81FF},
        {4'd4, 32'h44332211, 24'h332211}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_dn_n = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [NB*8-1:0] oe_bits;
    wire  sda_line = sda_m & ~sda_oe;

    int n_chk = 0;
    int n_err = 0;
    logic pd_drive_seen = 1'b0;

    always #2.5 clk = ~clk;

    oecfg_i2c_slave dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_dn_n (pwr_dn_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .oe_bits  (oe_bits)
    );

    always @(negedge clk) begin
        if (!pwr_dn_n && sda_oe) pd_drive_seen <= 1'b1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(1);
        scl_m = 1'b1; wq(1);
        sda_m = 1'b0; wq(1);
        scl_m = 1'b0; wq(1);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(1);
        scl_m = 1'b1; wq(1);
        sda_m = 1'b1; wq(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(1);
            scl_m = 1'b1; wq(2);
            scl_m = 1'b0; wq(1);
        end
        sda_m = 1'b1; wq(1);
        scl_m = 1'b1; wq(1);
        ack = ~sda_line;
        wq(1);
        scl_m = 1'b0; wq(1);
    endtask

    task automatic recv_byte(input logic give_nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(1);
            scl_m = 1'b1; wq(1);
            b[i] = sda_line;
            wq(1);
            scl_m = 1'b0; wq(1);
        end
        sda_m = give_nack; wq(1);
        scl_m = 1'b1; wq(2);
        scl_m = 1'b0; wq(1);
        sda_m = 1'b1;
    endtask

    // write with header; returns the number of bytes that got no ACK
    task automatic do_write(input logic [6:0] a, input int n, input logic [31:0] d,
                            input logic with_stop, output int misses);
        logic ack;
        misses = 0;
        bus_start();
        send_byte({a, 1'b0}, ack); if (!ack) misses++;
        send_byte(8'hA0, ack);     if (!ack) misses++;
        send_byte(8'(n), ack);     if (!ack) misses++;
        for (int k = 0; k < n; k++) begin
            send_byte(d[k*8 +: 8], ack); if (!ack) misses++;
        end
        if (with_stop) bus_stop();
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int misses;
        logic ack;
        logic [7:0] rb;

        repeat (5) @(negedge clk);
        check("R6 reset enables", 32'(oe_bits), 32'hFFFFFF);
        check("R6 reset sda released", 32'(sda_oe), 32'h0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R6 after reset release", 32'(oe_bits), 32'hFFFFFF);

        for (int v = 0; v < NVEC; v++) begin
            logic [3:0]  cnt;
            logic [31:0] dat;
            logic [23:0] exp;
            {cnt, dat, exp} = VEC[v];
            do_write(ADDR, int'(cnt), dat, 1'b1, misses);
            check("R4 acks on write", 32'(misses), 32'h0);
            if (cnt == 0)      check("R1 header only", 32'(oe_bits), 32'(exp));
            else if (cnt < NB) check("R3 partial write", 32'(oe_bits), 32'(exp));
            else               check("R2 ordered load", 32'(oe_bits), 32'(exp));
        end

        // R7: single bit position of register 0
        do_write(ADDR, 1, 32'h80, 1'b1, misses);
        check("R7 bit map reg0", 32'(oe_bits[7:0]), 32'h80);
        check("R7 other regs", 32'(oe_bits), 32'h332280);

        // R5: read back past the end
        bus_start();
        send_byte({ADDR, 1'b1}, ack);
        check("R5 read addr ack", 32'(ack), 32'h1);
        recv_byte(1'b0, rb); check("R5 byte0", 32'(rb), 32'h80);
        recv_byte(1'b0, rb); check("R5 byte1", 32'(rb), 32'h22);
        recv_byte(1'b0, rb); check("R5 byte2", 32'(rb), 32'h33);
        recv_byte(1'b1, rb); check("R5 past end", 32'(rb), 32'hFF);
        check("R5 released after nack", 32'(sda_oe), 32'h0);
        bus_stop();

        // R9: wrong address
        do_write(7'h12, 1, 32'h00, 1'b1, misses);
        check("R9 no ack anywhere", 32'(misses), 32'h4);
        check("R9 regs untouched", 32'(oe_bits), 32'h332280);

        // R10: restart during write resets index
        do_write(ADDR, 1, 32'h55, 1'b0, misses);
        do_write(ADDR, 1, 32'h66, 1'b1, misses);
        check("R10 restart acks", 32'(misses), 32'h0);
        check("R10 index reset", 32'(oe_bits), 32'h332266);
        bus_start();
        send_byte({ADDR, 1'b0}, ack);
        send_byte(8'h00, ack);
        bus_start();
        send_byte({ADDR, 1'b1}, ack);
        check("R10 restart to read ack", 32'(ack), 32'h1);
        recv_byte(1'b1, rb);
        check("R10 read after restart", 32'(rb), 32'h66);
        bus_stop();

        // R8: power-down
        pwr_dn_n = 1'b0;
        repeat (4) @(negedge clk);
        do_write(ADDR, 3, 32'h000000, 1'b1, misses);
        check("R8 no ack in power-down", 32'(misses), 32'h6);
        check("R8 regs frozen", 32'(oe_bits), 32'h332266);
        check("R8 sda never driven", 32'(pd_drive_seen), 32'h0);
        pwr_dn_n = 1'b1;
        repeat (4) @(negedge clk);
        do_write(ADDR, 1, 32'h01, 1'b1, misses);
        check("R8 works after wake", 32'(oe_bits), 32'h332201);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule